// File: doc/BRIEF.md
# Protection Identifier Permission Checker

This block decides whether a memory access may proceed once the page that holds it has been found. A page carries a 16-bit owner tag and a set of base rights. The checker compares the owner tag against the identifier slots held in four protection registers. The first slot whose identifier equals the tag supplies a rights mask. That mask either grants everything or, when the slot's write-disable bit is set, withholds write. The checker combines this mask with the page rights and reports the rights that remain. It also reports whether the requested access raises a fault, and which one.

There are two register layouts. In narrow mode only the low 32 bits of each register form a slot, which gives four slots. In wide mode each 64-bit register holds two slots, and the low half is searched before the high half, which gives eight slots. A request is presented for one cycle together with `req_valid`. The result appears on the next cycle with `out_valid` asserted and stays there until the next request. A two-state machine sequences this. It sits in `ST_IDLE` and moves to `ST_RESULT` on a request (the capture transition). It stays in `ST_RESULT` on back-to-back requests and returns to `ST_IDLE` when no request arrives (the release transition).

Top module: `pid_guard`

## Requirements
- R1: `out_valid` is high on exactly the cycle after each cycle with `req_valid` high, and low otherwise. The result outputs change only on those cycles.
- R2: After reset, `out_valid` and `fault_valid` are 0, `fault_code` is 2'b00 and `out_rights` is 3'b000.
- R3: Rights masks are 3 bits: bit 2 execute, bit 1 write, bit 0 read. `req_type` uses the same layout, with exactly one bit set or no bit set.
- R4: A slot is a 32-bit word. It matches when its bits [16:1] equal `access_id`. Bit 0 is write-disable: when it is set the slot grants 3'b101, and when it is clear the slot grants 3'b111.
- R5: Narrow mode (`wide_mode`=0) searches only `pid_bank[r*64 +: 32]` for r = 0 to 3, lowest r first. The upper 32 bits of every register are ignored. The first match decides.
- R6: Wide mode (`wide_mode`=1) searches eight slots in this order: reg0 low, reg0 high, reg1 low, reg1 high, and so on. The high half of register r is `pid_bank[r*64+32 +: 32]`. The first match decides.
- R7: When `access_id` is 0 or `priv_chk_en` is 0, no slot search is made and the page rights are used unchanged.
- R8: When `req_type` is 3'b000, no fault is raised and `out_rights` equals `page_rights`.
- R9: When the search is made and either no slot matches or the matched grant does not cover `req_type`, a protection-identifier fault is raised. The code is 2'b01 for an execute request and 2'b10 otherwise.
- R10: When the search passes, `out_rights` = `page_rights` AND grant. If that does not cover `req_type`, an access-rights fault is raised: code 2'b01 for execute, 2'b11 otherwise. When a search finds no match, `out_rights` is 3'b000.
- R11: `fault_valid` is 1 exactly when `fault_code` is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_type | input | 3 | Requested access {exec, write, read}, one-hot or zero |
| page_rights | input | 3 | Base rights of the page {exec, write, read} |
| access_id | input | 16 | Owner tag of the page; 0 marks a public page |
| priv_chk_en | input | 1 | Enables the identifier search for the current mode |
| wide_mode | input | 1 | 1 selects two slots per register |
| pid_bank | input | 256 | Four 64-bit protection registers, register 0 in the low bits |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_rights | output | 3 | Final granted rights |
| fault_valid | output | 1 | A fault was raised |
| fault_code | output | 2 | 00 none, 01 instruction, 10 data identifier, 11 data access rights |

## Verification
Two decisions can meet in the same cycle. The identifier search can pass while the combined page rights still refuse the access, and the order in which the two checks run then decides which fault is reported. The bench provokes this case directly. It places a matching write-disabled slot ahead of a permissive one and issues a read against a page that has no read right. It also issues a write against a page that allows writes, under a write-disabled match. The bench then expects the identifier fault whenever the grant refuses the access, and the access-rights fault only when the grant allows it. Random requests with seeded identifiers that often hit a slot repeat the same collision many times, and a bench model scores each result.

// File: rtl/pid_guard_pkg.sv
package pid_guard_pkg;
    localparam int RIGHTS_W = 3;
    localparam int RB_READ  = 0;
    localparam int RB_WRITE = 1;
    localparam int RB_EXEC  = 2;

    typedef enum logic [1:0] {
        FLT_NONE        = 2'b00,
        FLT_INSN        = 2'b01,
        FLT_DATA_PID    = 2'b10,
        FLT_DATA_RIGHTS = 2'b11
    } fault_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } guard_state_e;
endpackage

// File: rtl/pid_slot_cmp.sv
module pid_slot_cmp
    import pid_guard_pkg::*;
#(
    parameter int ID_W = 16
) (
    input  logic [ID_W-1:0]     access_id,
    input  logic [ID_W:0]       slot_word,
    output logic                hit,
    output logic [RIGHTS_W-1:0] grant
);
    assign hit   = (slot_word[ID_W:1] == access_id);
    assign grant = slot_word[0] ? 3'b101 : 3'b111;
endmodule

// File: rtl/pid_first_hit.sv
module pid_first_hit
    import pid_guard_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]          hits,
    input  logic [N*RIGHTS_W-1:0] grants,
    output logic                  any_hit,
    output logic [RIGHTS_W-1:0]   grant_sel
);
    always_comb begin
        any_hit   = 1'b0;
        grant_sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any_hit   = 1'b1;
                grant_sel = grants[i*RIGHTS_W +: RIGHTS_W];
            end
        end
    end
endmodule

// File: rtl/pid_guard.sv
module pid_guard
    import pid_guard_pkg::*;
#(
    parameter int ID_W     = 16,
    parameter int SLOT_W   = 32,
    parameter int NUM_REGS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [2:0]                   req_type,
    input  logic [2:0]                   page_rights,
    input  logic [ID_W-1:0]              access_id,
    input  logic                         priv_chk_en,
    input  logic                         wide_mode,
    input  logic [NUM_REGS*2*SLOT_W-1:0] pid_bank,
    output logic                         out_valid,
    output logic [2:0]                   out_rights,
    output logic                         fault_valid,
    output logic [1:0]                   fault_code
);
    localparam int REG_W     = 2 * SLOT_W;
    localparam int NUM_SLOTS = 2 * NUM_REGS;

    logic [NUM_SLOTS-1:0]          raw_hit;
    logic [NUM_SLOTS*RIGHTS_W-1:0] raw_grant;
    logic [NUM_SLOTS-1:0]          ord_hit;
    logic [NUM_SLOTS*RIGHTS_W-1:0] ord_grant;

    // Slot comparators: slot index 2*r+h, h=0 low half, h=1 high half
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar h = 0; h < 2; h++) begin : g_half
            logic [SLOT_W-1:0] word;
            logic              unused_hi;
            assign word      = pid_bank[r*REG_W + h*SLOT_W +: SLOT_W];
            assign unused_hi = ^word[SLOT_W-1:ID_W+1];
            pid_slot_cmp #(.ID_W(ID_W)) i_cmp (
                .access_id (access_id),
                .slot_word (word[ID_W:0]),
                .hit       (raw_hit[2*r+h]),
                .grant     (raw_grant[(2*r+h)*RIGHTS_W +: RIGHTS_W])
            );
        end
    end

    // Search order: wide keeps 2r+h; narrow packs low halves into 0..NUM_REGS-1
    always_comb begin
        ord_hit   = '0;
        ord_grant = '0;
        if (wide_mode) begin
            ord_hit   = raw_hit;
            ord_grant = raw_grant;
        end else begin
            for (int r = 0; r < NUM_REGS; r++) begin
                ord_hit[r] = raw_hit[2*r];
                ord_grant[r*RIGHTS_W +: RIGHTS_W] = raw_grant[2*r*RIGHTS_W +: RIGHTS_W];
            end
        end
    end

    logic                any_hit;
    logic [RIGHTS_W-1:0] sel_grant;

    pid_first_hit #(.N(NUM_SLOTS)) i_first (
        .hits      (ord_hit),
        .grants    (ord_grant),
        .any_hit   (any_hit),
        .grant_sel (sel_grant)
    );

    // Decision logic
    logic          is_exec;
    logic          skip_pid;
    logic [2:0]    nxt_rights;
    fault_e        nxt_fault;

    assign is_exec  = req_type[RB_EXEC];
    assign skip_pid = (access_id == '0) || !priv_chk_en;

    always_comb begin
        nxt_rights = page_rights;
        nxt_fault  = FLT_NONE;
        if (req_type != 3'b000) begin
            if (!skip_pid) begin
                nxt_rights = any_hit ? (page_rights & sel_grant) : 3'b000;
                if (!any_hit || ((req_type & sel_grant) == 3'b000)) begin
                    nxt_fault = is_exec ? FLT_INSN : FLT_DATA_PID;
                end else if ((req_type & nxt_rights) == 3'b000) begin
                    nxt_fault = is_exec ? FLT_INSN : FLT_DATA_RIGHTS;
                end
            end else if ((req_type & page_rights) == 3'b000) begin
                nxt_fault = is_exec ? FLT_INSN : FLT_DATA_RIGHTS;
            end
        end
    end

    // State register
    guard_state_e state, state_nxt;

    always_comb begin
        unique case (state)
            ST_IDLE:   state_nxt = req_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_nxt = req_valid ? ST_RESULT : ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_rights  <= '0;
            fault_code  <= FLT_NONE;
            fault_valid <= 1'b0;
        end else if (req_valid) begin
            out_rights  <= nxt_rights;
            fault_code  <= nxt_fault;
            fault_valid <= (nxt_fault != FLT_NONE);
        end
    end

    assign out_valid = (state == ST_RESULT);

    // R3
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot0(req_type));

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid && $stable(fault_code) && $stable(out_rights));

    // R8
    empty_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_type == 3'b000 |=>
            fault_code == FLT_NONE && out_rights == $past(page_rights));

    // R10
    rights_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_rights & ~$past(page_rights)) == 3'b000);

    // R7
    skip_no_pid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && skip_pid |=> fault_code != FLT_DATA_PID);

    // R11
    flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> fault_valid == (fault_code != FLT_NONE));
endmodule

// File: tb/test_pid_guard.sv
`timescale 1ns/1ps
module test_pid_guard;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [2:0]   req_type = '0;
    logic [2:0]   page_rights = '0;
    logic [15:0]  access_id = '0;
    logic         priv_chk_en = 1'b0;
    logic         wide_mode = 1'b0;
    logic [255:0] pid_bank = '0;
    logic         out_valid;
    logic [2:0]   out_rights;
    logic         fault_valid;
    logic [1:0]   fault_code;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    pid_guard i_pid_guard (
        .clk, .rst_n, .req_valid, .req_type, .page_rights, .access_id,
        .priv_chk_en, .wide_mode, .pid_bank,
        .out_valid, .out_rights, .fault_valid, .fault_code
    );

    // Bench model: returns {rights, code}
    function automatic logic [4:0] model(input logic [2:0] t, input logic [2:0] pg,
                                         input logic [15:0] id, input logic en,
                                         input logic wide, input logic [255:0] bank);
        logic [2:0]  g;
        logic        found;
        logic [31:0] s;
        logic [2:0]  eff;
        logic        ex;
        g = 3'b000;
        found = 1'b0;
        ex = t[2];
        if (t == 3'b000) return {pg, 2'b00};
        if (id == 16'h0 || !en) begin
            if ((t & pg) == 3'b000) return {pg, ex ? 2'b01 : 2'b11};
            return {pg, 2'b00};
        end
        for (int k = 0; k < 8; k++) begin
            if (!found && (wide || k < 4)) begin
                s = wide ? bank[(k/2)*64 + (k%2)*32 +: 32] : bank[k*64 +: 32];
                if (s[16:1] == id) begin
                    found = 1'b1;
                    g = s[0] ? 3'b101 : 3'b111;
                end
            end
        end
        eff = found ? (pg & g) : 3'b000;
        if (!found || (t & g) == 3'b000) return {eff, ex ? 2'b01 : 2'b10};
        if ((t & eff) == 3'b000) return {eff, ex ? 2'b01 : 2'b11};
        return {eff, 2'b00};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put_slot(input int r, input int h, input logic [15:0] id, input logic wd);
        pid_bank[r*64 + h*32 +: 32] = {15'h0, id, wd};
    endtask

    task automatic run(input string tag, input logic [2:0] t, input logic [2:0] pg,
                       input logic [15:0] id, input logic en, input logic wide);
        logic [4:0] e;
        @(negedge clk);
        req_type = t; page_rights = pg; access_id = id;
        priv_chk_en = en; wide_mode = wide; req_valid = 1'b1;
        e = model(t, pg, id, en, wide, pid_bank);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R1 valid"}, 32'(out_valid), 32'd1);
        chk({tag, " rights"}, 32'(out_rights), 32'(e[4:2]));
        chk({tag, " code"}, 32'(fault_code), 32'(e[1:0]));
        chk({tag, " R11 flag"}, 32'(fault_valid), 32'(e[1:0] != 2'b00));
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        #20;
        chk("R2 valid", 32'(out_valid), 0);
        chk("R2 flag", 32'(fault_valid), 0);
        chk("R2 code", 32'(fault_code), 0);
        chk("R2 rights", 32'(out_rights), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 write-disable slot refuses write, allows read
        pid_bank = '0;
        put_slot(0, 0, 16'h1234, 1'b1);
        run("R4 wd write", 3'b010, 3'b111, 16'h1234, 1'b1, 1'b0);
        run("R4 wd read", 3'b001, 3'b111, 16'h1234, 1'b1, 1'b0);
        // R1 out_valid drops with no request
        @(negedge clk);
        chk("R1 idle", 32'(out_valid), 0);
        // R5 narrow ignores high half
        pid_bank = '0;
        put_slot(1, 1, 16'h00AA, 1'b0);
        run("R5 narrow hi ignored", 3'b001, 3'b111, 16'h00AA, 1'b1, 1'b0);
        // R6 wide uses high half
        run("R6 wide hi", 3'b001, 3'b111, 16'h00AA, 1'b1, 1'b1);
        // R6 order: reg0 high before reg1 low
        pid_bank = '0;
        put_slot(0, 1, 16'h0042, 1'b1);
        put_slot(1, 0, 16'h0042, 1'b0);
        run("R6 order", 3'b010, 3'b111, 16'h0042, 1'b1, 1'b1);
        // R5 narrow then sees reg1 low first
        run("R5 order", 3'b010, 3'b111, 16'h0042, 1'b1, 1'b0);
        // R7 public page and disabled check
        run("R7 public", 3'b010, 3'b011, 16'h0000, 1'b1, 1'b0);
        run("R7 disabled", 3'b010, 3'b011, 16'h7777, 1'b0, 1'b0);
        // R8 empty type
        run("R8 empty", 3'b000, 3'b100, 16'h7777, 1'b1, 1'b1);
        // R9 no match, exec and data
        run("R9 nomatch exec", 3'b100, 3'b111, 16'h7777, 1'b1, 1'b1);
        run("R9 nomatch data", 3'b001, 3'b111, 16'h7777, 1'b1, 1'b1);
        // R10 pass id check but page lacks right
        pid_bank = '0;
        put_slot(2, 0, 16'h0101, 1'b1);
        put_slot(3, 0, 16'h0101, 1'b0);
        run("R10 rights data", 3'b001, 3'b110, 16'h0101, 1'b1, 1'b0);
        run("R10 rights exec", 3'b100, 3'b011, 16'h0101, 1'b1, 1'b0);
        run("R9 wd beats later", 3'b010, 3'b010, 16'h0101, 1'b1, 1'b0);

        // R10 random mixed
        for (int n = 0; n < 400; n++) begin
            logic [15:0] id;
            logic [2:0]  t;
            for (int w = 0; w < 8; w++) pid_bank[w*32 +: 32] = $urandom;
            id = 16'($urandom_range(0, 3));
            for (int w = 0; w < 8; w++)
                if ($urandom_range(0, 3) == 0) pid_bank[w*32+1 +: 16] = id;
            case ($urandom_range(0, 3))
                0: t = 3'b000;
                1: t = 3'b001;
                2: t = 3'b010;
                default: t = 3'b100;
            endcase
            run("R10 random", t, 3'($urandom), id, ($urandom_range(0, 4) != 0),
                1'($urandom));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule